// File: doc/BRIEF.md
# Multi-Channel RAM Error Injector

This block sits between a RAM read port and the ECC checker behind it and deliberately corrupts returned reads so that the checker's detection and correction paths can be exercised. Several independent channels are provided, one per target RAM. Each channel holds a 64-bit data inversion mask, an 8-bit checkbit inversion mask and an arm bit. A single global injection switch gates all channels. A read is corrupted only when its target channel is armed and the global switch is on. The returned data and checkbits are then XORed with that channel's masks.

Software programs the block through a simple 32-bit register port with one write strobe and combinational read-back. Each channel descriptor occupies a 16-byte slot with three live words: checkbit mask, upper data half and lower data half. Writing any live descriptor word disarms that channel, so software must re-arm after reprogramming. An armed channel keeps corrupting every read until software disarms it.

Two reset inputs exist. The power-on reset clears everything. The warm (system) reset clears only the global switch and the output strobe. Each channel's arm logic is a two-state machine. CH_DISARMED moves to CH_ARMED when the enable register is written with that channel's bit at 1. CH_ARMED moves back to CH_DISARMED when a descriptor word of the channel is written, or when the enable register is written with that bit at 0.

Top module: `ram_fault_injector`

## Requirements
- R1: After power-on reset (`por_n` low for at least one clock edge), `out_valid` is 0 and the control word, the enable register and every descriptor word all read back as 0.
- R2: Register map (byte addresses, bits [1:0] zero):
  - 0x000 holds the global switch in bit 0.
  - 0x004 holds the arm bits, with channel n in bit n.
  - Channel n's descriptor starts at 0x100 + 16·n. Offset +0 is the checkbit mask in bits [7:0], with upper bits reading 0. Offset +4 is data mask bits 63..32. Offset +8 is data mask bits 31..0.
  - Offset +12 always reads 0, and writes to it change nothing.
- R3: When the global switch is 0, or the target channel's arm bit is 0, the read data and checkbits pass through unchanged.
- R4: When the global switch is 1 and the channel selected by `rd_target` is armed, `out_data` = `rd_data` XOR data mask and `out_chk` = `rd_chk` XOR checkbit mask. Other channels' masks have no effect.
- R5: `out_valid` equals `rd_valid` delayed by exactly one clock, and the corrupted word appears on the same cycle as that strobe.
- R6: An armed channel corrupts every later read to its target with the same masks, for as long as no register write disarms it.
- R7: A write to descriptor offset +0, +4 or +8 of channel n clears channel n's arm bit at that clock edge and leaves other channels' arm bits alone. A write to offset +12 does not clear it.
- R8: While `sys_rst_n` is low, the global switch is cleared, `out_valid` is 0 and register writes are ignored. The arm bits and masks keep their values, so after release setting the global switch resumes injection without re-arming.
- R9: A write to 0x004 loads every channel's arm bit from the written value (1 arms, 0 disarms), and a write to 0x000 loads the global switch from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| sys_rst_n | input | 1 | Warm reset, active low, synchronous; clears global switch and output strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| rd_valid | input | 1 | Incoming RAM read is valid |
| rd_target | input | CH_W | Channel (target RAM) of the incoming read |
| rd_data | input | 64 | Incoming read data |
| rd_chk | input | 8 | Incoming checkbits |
| out_valid | output | 1 | Outgoing read valid, one clock after `rd_valid` |
| out_data | output | 64 | Read data after fault injection |
| out_chk | output | 8 | Checkbits after fault injection |

## Verification
Every cycle, the assertions check the one-cycle strobe alignment, pass-through while the global switch is off, disarming on a descriptor write, arm-bit stability with no write, and arm-bit retention across warm reset. Only the bench's scenarios can show three things: that the XOR actually uses the mask of the channel named by `rd_target`, that the readback layout matches the register map, and that a write to the padding word leaves the channel armed. The bench also shows that a power-on reset after a warm reset wipes the masks. A behavioural model runs alongside the design and compares every output strobe and every corrupted word.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
    localparam int WORD_W      = 32;
    localparam int DATA_W      = 64;
    localparam int CHK_W       = 8;
    localparam int CTRL_WORD   = 0;      // word index of global switch
    localparam int ARM_WORD    = 1;      // word index of arm bits
    localparam int DESC_BASE   = 'h100;
    localparam int DESC_STRIDE = 16;

    typedef enum logic [1:0] {
        SLOT_CHK = 2'd0,
        SLOT_HI  = 2'd1,
        SLOT_LO  = 2'd2,
        SLOT_PAD = 2'd3
    } desc_slot_e;

    typedef enum logic {
        CH_DISARMED = 1'b0,
        CH_ARMED    = 1'b1
    } arm_state_e;

    typedef struct packed {
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
    } fault_mask_t;
endpackage

// File: rtl/rfi_addr_dec.sv
module rfi_addr_dec import rfi_pkg::*; #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ctrl_hit,
    output logic              arm_hit,
    output logic [NCH-1:0]    desc_sel,
    output desc_slot_e        slot
);
    logic aligned;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        ctrl_hit = aligned && (addr[ADDR_W-1:2] == (ADDR_W-2)'(CTRL_WORD));
        arm_hit  = aligned && (addr[ADDR_W-1:2] == (ADDR_W-2)'(ARM_WORD));
        slot     = desc_slot_e'(addr[3:2]);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_sel
        localparam int SLOT_BASE = DESC_BASE + c * DESC_STRIDE;
        assign desc_sel[c] = aligned &&
            (addr[ADDR_W-1:4] == (ADDR_W-4)'(SLOT_BASE / DESC_STRIDE));
    end
endmodule

// File: rtl/rfi_desc_bank.sv
module rfi_desc_bank import rfi_pkg::*; #(
    parameter int NCH = 4
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    wr_ok,
    input  logic [NCH-1:0]          desc_sel,
    input  desc_slot_e              slot,
    input  logic [WORD_W-1:0]       wdata,
    output fault_mask_t [NCH-1:0]   mask_q,
    output logic [NCH-1:0]          desc_wr
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fault_mask_t m_q;

        assign desc_wr[c] = wr_ok && desc_sel[c] && (slot != SLOT_PAD);
        assign mask_q[c]  = m_q;

        always_ff @(posedge clk) begin
            if (!por_n) begin
                m_q <= '0;
            end else if (desc_wr[c]) begin
                unique case (slot)
                    SLOT_CHK: m_q.chk                  <= wdata[CHK_W-1:0];
                    SLOT_HI:  m_q.data[DATA_W-1:WORD_W] <= wdata;
                    SLOT_LO:  m_q.data[WORD_W-1:0]      <= wdata;
                    default:  m_q                      <= m_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/rfi_arm_fsm.sv
module rfi_arm_fsm import rfi_pkg::*; (
    input  logic clk,
    input  logic por_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic desc_wr,
    output logic armed
);
    arm_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= CH_DISARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_DISARMED: if (set_req && !desc_wr)  st_d = CH_ARMED;
            CH_ARMED:    if (desc_wr || clr_req)   st_d = CH_DISARMED;
            default:                               st_d = CH_DISARMED;
        endcase
    end

    always_comb armed = (st_q == CH_ARMED);
endmodule

// File: rtl/rfi_fault_xor.sv
module rfi_fault_xor import rfi_pkg::*; #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  sys_rst_n,
    input  logic                  rd_valid,
    input  logic [CH_W-1:0]       rd_target,
    input  logic [DATA_W-1:0]     rd_data,
    input  logic [CHK_W-1:0]      rd_chk,
    input  logic [NCH-1:0]        active,
    input  fault_mask_t [NCH-1:0] mask,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    output logic [CHK_W-1:0]      out_chk
);
    fault_mask_t sel;

    always_comb begin
        sel = '0;
        for (int c = 0; c < NCH; c++) begin
            if (active[c] && (rd_target == CH_W'(c))) sel = mask[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n || !sys_rst_n) out_valid <= 1'b0;
        else                      out_valid <= rd_valid;
    end

    always_ff @(posedge clk) begin
        if (rd_valid) begin
            out_data <= rd_data ^ sel.data;
            out_chk  <= rd_chk ^ sel.chk;
        end
    end
endmodule

// File: rtl/ram_fault_injector.sv
module ram_fault_injector import rfi_pkg::*; #(
    parameter int  NCH    = 4,
    parameter int  ADDR_W = 12,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              rd_valid,
    input  logic [CH_W-1:0]   rd_target,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CHK_W-1:0]  out_chk
);
    logic                  wr_ok;
    logic                  ctrl_hit;
    logic                  arm_hit;
    logic [NCH-1:0]        desc_sel;
    desc_slot_e            slot;
    fault_mask_t [NCH-1:0] mask_q;
    logic [NCH-1:0]        desc_wr;
    logic [NCH-1:0]        chan_en;
    logic [NCH-1:0]        active;
    logic                  gen_en;

    assign wr_ok  = reg_wr && por_n && sys_rst_n;
    assign active = chan_en & {NCH{gen_en}};

    rfi_addr_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .addr     (reg_addr),
        .ctrl_hit (ctrl_hit),
        .arm_hit  (arm_hit),
        .desc_sel (desc_sel),
        .slot     (slot)
    );

    rfi_desc_bank #(.NCH(NCH)) u_bank (
        .clk      (clk),
        .por_n    (por_n),
        .wr_ok    (wr_ok),
        .desc_sel (desc_sel),
        .slot     (slot),
        .wdata    (reg_wdata),
        .mask_q   (mask_q),
        .desc_wr  (desc_wr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_arm
        rfi_arm_fsm u_fsm (
            .clk     (clk),
            .por_n   (por_n),
            .set_req (wr_ok && arm_hit && reg_wdata[c]),
            .clr_req (wr_ok && arm_hit && !reg_wdata[c]),
            .desc_wr (desc_wr[c]),
            .armed   (chan_en[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!por_n || !sys_rst_n)    gen_en <= 1'b0;
        else if (wr_ok && ctrl_hit)  gen_en <= reg_wdata[0];
    end

    always_comb begin
        reg_rdata = '0;
        if (ctrl_hit) begin
            reg_rdata = WORD_W'(gen_en);
        end else if (arm_hit) begin
            reg_rdata = WORD_W'(chan_en);
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (desc_sel[c]) begin
                    unique case (slot)
                        SLOT_CHK: reg_rdata = WORD_W'(mask_q[c].chk);
                        SLOT_HI:  reg_rdata = mask_q[c].data[DATA_W-1:WORD_W];
                        SLOT_LO:  reg_rdata = mask_q[c].data[WORD_W-1:0];
                        default:  reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    rfi_fault_xor #(.NCH(NCH), .CH_W(CH_W)) u_xor (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .rd_valid  (rd_valid),
        .rd_target (rd_target),
        .rd_data   (rd_data),
        .rd_chk    (rd_chk),
        .active    (active),
        .mask      (mask_q),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_chk   (out_chk)
    );
endmodule

// File: rtl/rfi_checker.sv
module rfi_checker import rfi_pkg::*; #(
    parameter int NCH = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst_n,
    input logic              reg_wr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [CHK_W-1:0]  rd_chk,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [CHK_W-1:0]  out_chk,
    input logic              gen_en,
    input logic [NCH-1:0]    chan_en,
    input logic [NCH-1:0]    desc_wr
);
    assert_valid_follow_R5: assert property (@(posedge clk) disable iff (!por_n)
        (rd_valid && sys_rst_n) |=> out_valid);

    assert_valid_idle_R5: assert property (@(posedge clk) disable iff (!por_n)
        (!rd_valid || !sys_rst_n) |=> !out_valid);

    assert_passthru_R3: assert property (@(posedge clk) disable iff (!por_n)
        (rd_valid && sys_rst_n && !gen_en) |=>
            (out_data == $past(rd_data) && out_chk == $past(rd_chk)));

    assert_disarm_on_desc_R7: assert property (@(posedge clk) disable iff (!por_n)
        (|desc_wr) |=> ((chan_en & $past(desc_wr)) == '0));

    assert_arm_persist_R6: assert property (@(posedge clk) disable iff (!por_n)
        !reg_wr |=> $stable(chan_en));

    assert_warm_keep_R8: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> ($stable(chan_en) && !gen_en));
endmodule

bind ram_fault_injector rfi_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .reg_wr    (reg_wr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_chk    (rd_chk),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_chk   (out_chk),
    .gen_en    (gen_en),
    .chan_en   (chan_en),
    .desc_wr   (desc_wr)
);

// File: tb/sim_ram_fault_injector.sv
module sim_ram_fault_injector;
    localparam int CLK_P = 10;
    localparam int NCH   = 4;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_valid = 1'b0;
    logic [1:0]  rd_target = '0;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_chk = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [7:0]  out_chk;

    ram_fault_injector #(.NCH(NCH), .ADDR_W(12)) u0 (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rd_valid(rd_valid), .rd_target(rd_target),
        .rd_data(rd_data), .rd_chk(rd_chk), .out_valid(out_valid),
        .out_data(out_data), .out_chk(out_chk)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_run = 0;
    int n_fail = 0;

    // behavioural reference state
    logic [63:0]    m_d [NCH];
    logic [7:0]     m_c [NCH];
    logic [NCH-1:0] m_en;
    logic           m_gen;
    logic           e_valid;
    logic [63:0]    e_data;
    logic [7:0]     e_chk;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_d[c] = '0;
            m_c[c] = '0;
        end
        m_en  = '0;
        m_gen = 1'b0;
    endtask

    task automatic model_write(logic [11:0] a, logic [31:0] d);
        int c;
        if (a == 12'h000) m_gen = d[0];
        else if (a == 12'h004) m_en = d[NCH-1:0];
        else if (a >= 12'h100 && a < 12'h100 + NCH * 16 && a[1:0] == 2'b00) begin
            c = (int'(a) - 'h100) / 16;
            case (a[3:2])
                2'd0: begin m_c[c] = d[7:0];         m_en[c] = 1'b0; end
                2'd1: begin m_d[c][63:32] = d;       m_en[c] = 1'b0; end
                2'd2: begin m_d[c][31:0] = d;        m_en[c] = 1'b0; end
                default: ;
            endcase
        end
    endtask

    task automatic step();
        @(posedge clk);
        e_valid = por_n && sys_rst_n && rd_valid;
        e_data  = rd_data ^ ((m_gen && m_en[rd_target]) ? m_d[rd_target] : 64'h0);
        e_chk   = rd_chk ^ ((m_gen && m_en[rd_target]) ? m_c[rd_target] : 8'h0);
        if (!por_n)          model_reset();
        else if (!sys_rst_n) m_gen = 1'b0;
        else if (reg_wr)     model_write(reg_addr, reg_wdata);
        @(negedge clk);
        check("R5", "out_valid", 64'(out_valid), 64'(e_valid));
        if (e_valid) begin
            check("R4", "out_data", out_data, e_data);
            check("R4", "out_chk", 64'(out_chk), 64'(e_chk));
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [11:0] a, logic [31:0] exp, string req);
        reg_addr = a;
        #1;
        check(req, $sformatf("readback @%h", a), 64'(reg_rdata), 64'(exp));
    endtask

    task automatic ram_read(logic [1:0] t, logic [63:0] d, logic [7:0] k);
        rd_valid = 1'b1; rd_target = t; rd_data = d; rd_chk = k;
        step();
        rd_valid = 1'b0;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [7:0]  k;
        model_reset();
        // R1: power-on reset
        por_n = 1'b0;
        repeat (3) step();
        check("R1", "out_valid in reset", 64'(out_valid), 64'h0);
        por_n = 1'b1;
        step();
        rd_reg(12'h000, 32'h0, "R1");
        rd_reg(12'h004, 32'h0, "R1");
        rd_reg(12'h114, 32'h0, "R1");

        // R2: program channel 1 and channel 2, check layout
        wr(12'h110, 32'hFFFF_FFA5);
        wr(12'h114, 32'h8000_0001);
        wr(12'h118, 32'h0000_F00F);
        wr(12'h11C, 32'hDEAD_BEEF);
        rd_reg(12'h110, 32'h0000_00A5, "R2");
        rd_reg(12'h114, 32'h8000_0001, "R2");
        rd_reg(12'h118, 32'h0000_F00F, "R2");
        rd_reg(12'h11C, 32'h0, "R2");
        wr(12'h120, 32'h0000_003C);
        wr(12'h124, 32'h0000_0000);
        wr(12'h128, 32'hFFFF_FFFF);
        rd_reg(12'h120, 32'h0000_003C, "R2");

        // R3: nothing armed, global off
        d = 64'h0123_4567_89AB_CDEF; k = 8'h5A;
        ram_read(2'd1, d, k);
        check("R3", "pass data", out_data, d);
        // R9 arm channel 1 only, global still off
        wr(12'h004, 32'h2);
        rd_reg(12'h004, 32'h2, "R9");
        ram_read(2'd1, d, k);
        check("R3", "pass with global off", out_data, d);
        check("R3", "pass chk with global off", 64'(out_chk), 64'(k));

        // R4: global on, channel 1 corrupted
        wr(12'h000, 32'h1);
        rd_reg(12'h000, 32'h1, "R9");
        ram_read(2'd1, d, k);
        check("R4", "corrupt data", out_data, d ^ 64'h8000_0001_0000_F00F);
        check("R4", "corrupt chk", 64'(out_chk), 64'(k ^ 8'hA5));
        ram_read(2'd0, d, k);
        check("R4", "other channel clean", out_data, d);

        // R6: persistence over repeated reads
        for (int i = 0; i < 5; i++) begin
            d = {$urandom, $urandom};
            ram_read(2'd1, d, 8'h00);
            check("R6", "repeat corrupt", out_data, d ^ 64'h8000_0001_0000_F00F);
            check("R6", "repeat chk", 64'(out_chk), 64'hA5);
        end

        // R5: back-to-back burst, model checks every cycle
        for (int i = 0; i < 8; i++) begin
            rd_valid = 1'b1; rd_target = 2'($urandom); rd_data = {$urandom, $urandom};
            rd_chk = 8'($urandom);
            step();
        end
        rd_valid = 1'b0;
        step();

        // R7: descriptor write disarms only that channel
        wr(12'h004, 32'h6);
        wr(12'h114, 32'h8000_0001);
        rd_reg(12'h004, 32'h4, "R7");
        d = 64'hFFFF_0000_AAAA_5555;
        ram_read(2'd1, d, 8'h11);
        check("R7", "disarmed channel clean", out_data, d);
        wr(12'h12C, 32'h5);
        rd_reg(12'h004, 32'h4, "R7");
        rd_reg(12'h12C, 32'h0, "R2");
        ram_read(2'd2, d, 8'h11);
        check("R7", "pad write keeps arm", out_data, d ^ 64'h0000_0000_FFFF_FFFF);
        check("R7", "pad write keeps arm chk", 64'(out_chk), 64'(8'h11 ^ 8'h3C));

        // R9: clear arm bits by enable write
        wr(12'h004, 32'h0);
        rd_reg(12'h004, 32'h0, "R9");
        ram_read(2'd2, d, 8'h11);
        check("R9", "disarmed by enable write", out_data, d);

        // R8: warm reset keeps arm bits and masks
        wr(12'h004, 32'h6);
        sys_rst_n = 1'b0;
        rd_valid = 1'b1; rd_target = 2'd1; rd_data = d;
        step();
        reg_wr = 1'b1; reg_addr = 12'h004; reg_wdata = 32'h0;
        step();
        reg_wr = 1'b0;
        check("R8", "out_valid in warm reset", 64'(out_valid), 64'h0);
        rd_valid = 1'b0;
        sys_rst_n = 1'b1;
        step();
        rd_reg(12'h000, 32'h0, "R8");
        rd_reg(12'h004, 32'h6, "R8");
        rd_reg(12'h114, 32'h8000_0001, "R8");
        ram_read(2'd2, d, 8'h00);
        check("R8", "global off after warm reset", out_data, d);
        wr(12'h000, 32'h1);
        ram_read(2'd1, d, 8'h00);
        check("R8", "resume without re-arm", out_data, d ^ 64'h8000_0001_0000_F00F);

        // R1: power-on reset clears everything
        por_n = 1'b0;
        repeat (2) step();
        por_n = 1'b1;
        step();
        rd_reg(12'h004, 32'h0, "R1");
        rd_reg(12'h000, 32'h0, "R1");
        rd_reg(12'h114, 32'h0, "R1");
        ram_read(2'd1, d, 8'h77);
        check("R1", "clean after por", out_data, d);

        // mixed random traffic against the model
        for (int i = 0; i < 300; i++) begin
            int sel;
            sel = int'($urandom % 10);
            rd_valid = ($urandom % 3) != 0;
            rd_target = 2'($urandom);
            rd_data = {$urandom, $urandom};
            rd_chk = 8'($urandom);
            reg_wr = 1'b0;
            if (sel == 0) begin
                reg_wr = 1'b1; reg_addr = 12'h004; reg_wdata = $urandom;
            end else if (sel == 1) begin
                reg_wr = 1'b1; reg_addr = 12'h000; reg_wdata = $urandom;
            end else if (sel == 2) begin
                reg_wr = 1'b1;
                reg_addr = 12'h100 + 12'(($urandom % NCH) * 16) + 12'(($urandom % 4) * 4);
                reg_wdata = $urandom;
            end
            step();
        end
        reg_wr = 1'b0;
        rd_valid = 1'b0;
        step();

        report();
        $finish;
    end
endmodule